// File: doc/BRIEF.md
# Programmable panel timing generator

This block produces horizontal sync, vertical sync and data-enable for a parallel RGB display panel. It runs on the pixel clock. A host writes a small set of configuration registers through a single-cycle write port. Horizontal quantities are given in pixels within a line. Vertical quantities are given as absolute pixel-clock positions within the whole frame. A single free-running frame counter is compared against the vertical sync width and against both edges of the active window. Because those edges are plain pixel positions, any horizontal skew is already folded into the programmed values. The block also emits a one-cycle pulse on the first pixel of every frame, and a sticky status flag that software can poll and then clear by writing. Inside the active window it reports the x and y position of the current pixel.

Configuration writes go into a staging copy. The counters and decoders use a second, working copy, which is loaded from the staging copy while the block is stopped and again at every frame wrap. A running frame therefore never mixes old and new settings. A two-state controller sequences operation. In TG_IDLE the counters are held at zero, the working copy tracks the staging copy, and all outputs sit at their inactive levels. The transition TG_IDLE→TG_RUN happens on a write of 1 to the enable bit. In TG_RUN both counters advance, and the frame wrap (TG_RUN→TG_RUN) reloads the working copy. The transition TG_RUN→TG_IDLE happens on a write of 0 to the enable bit.

Top module: `panel_timing_gen`

## Requirements
- R1: After reset, hsync_o, vsync_o and de_o are low, and frame_start_o, frame_irq_o, pix_x_o and pix_y_o are zero. The block is stopped and all staged and working settings are zero.
- R2: Write addresses are decoded as follows. Any other address has no effect.
  - 0: bit 0 enables the block.
  - 1: line period in bits [27:16], hsync width in bits [11:0].
  - 2: frame period in bits [23:0].
  - 3: vsync width in bits [23:0].
  - 4: last active pixel in bits [27:16], first active pixel in bits [11:0].
  - 5: active-frame start in bits [23:0].
  - 6: active-frame end in bits [23:0].
  - 7: polarity in bits [2:0].
  - 8: status clear, using bit 0.
- R3: The line count h runs 0..line_period-1 and the frame count f runs 0..frame_period-1. The line count also returns to 0 when the frame count wraps. Both counts are zero at the first running cycle after enable. The outputs are registered: outputs after clock edge k reflect the counts present before that edge, so the first outputs after the enabling edge belong to count 0.
- R4: The hsync level is active while h < hsync width.
- R5: The vsync level is active while f < vsync width.
- R6: The DE level is active when active_start <= f <= active_end and first_pixel <= h <= last_pixel.
- R7: Polarity bit 0 inverts hsync_o, bit 1 inverts vsync_o and bit 2 inverts de_o. While the block is stopped, each pin rests at its inactive level, which equals its polarity bit.
- R8: frame_start_o is high for exactly the one output cycle that belongs to f == 0 of every running frame.
- R9: frame_irq_o is set together with frame_start_o. It stays set until a write to address 8 with bit 0 set. Writing 0 has no effect. If a set and a clear occur in the same cycle, the set wins.
- R10: A write of 0 to the enable bit stops the block. The outputs for the writing edge are still normal. From the next edge on, frame_start_o is low and the pins are inactive. The counters return to zero.
- R11: Setting writes made while running take effect at the first cycle of the next frame (f == 0). Writes made while stopped are in effect at the first cycle after enable.
- R12: While DE is active, pix_x_o equals h minus first_pixel, and pix_y_o is 0 on the first active cycle of a frame. pix_y_o then increments on each later active cycle with h == first_pixel. Outside DE, pix_x_o is 0 and pix_y_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync pin, polarity applied |
| vsync_o | output | 1 | Vertical sync pin, polarity applied |
| de_o | output | 1 | Data-enable pin, polarity applied |
| frame_start_o | output | 1 | One-cycle pulse on the first pixel of each frame |
| frame_irq_o | output | 1 | Sticky frame-start status |
| pix_x_o | output | 12 | Pixel column inside the active window |
| pix_y_o | output | 12 | Pixel row inside the active window |

## Verification
The assertions check several rules on every cycle.
- The status flag is sticky, and it clears only on a clear write that does not coincide with a new frame start.
- Every frame-start pulse coincides with a set status flag.
- While the block is stopped, the pins sit at their inactive levels.
- The counters start at zero on enable, and the line count stays below the line period.

The actual sync, DE and coordinate waveforms need the bench's scenarios. Those scenarios cover staged settings switching over exactly at a frame boundary, polarity inversion, a skewed active window starting mid-line, and clear writes landing at varying distances from frame start.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int HW = 12;   // horizontal field width
    localparam int FW = 24;   // frame position width
    localparam int AW = 4;    // write address width
    localparam int DW = 32;   // write data width
    localparam int PW = 3;    // polarity bits

    localparam logic [AW-1:0] A_ENABLE = 4'd0;
    localparam logic [AW-1:0] A_LINE   = 4'd1;
    localparam logic [AW-1:0] A_FPER   = 4'd2;
    localparam logic [AW-1:0] A_VSW    = 4'd3;
    localparam logic [AW-1:0] A_HWIN   = 4'd4;
    localparam logic [AW-1:0] A_VSTART = 4'd5;
    localparam logic [AW-1:0] A_VEND   = 4'd6;
    localparam logic [AW-1:0] A_POL    = 4'd7;
    localparam logic [AW-1:0] A_CLEAR  = 4'd8;

    typedef struct packed {
        logic [HW-1:0] lper;
        logic [HW-1:0] hsw;
        logic [HW-1:0] hstart;
        logic [HW-1:0] hend;
        logic [FW-1:0] fper;
        logic [FW-1:0] vsw;
        logic [FW-1:0] vstart;
        logic [FW-1:0] vend;
        logic [PW-1:0] pol;
    } tg_cfg_t;

    typedef enum logic [0:0] {
        TG_IDLE = 1'b0,
        TG_RUN  = 1'b1
    } tg_state_e;
endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          run,
    input  logic          frame_wrap,
    output tg_cfg_t       act,
    output logic          en_set,
    output logic          en_clr,
    output logic          clr
);
    tg_cfg_t stg_q;
    tg_cfg_t act_q;

    always_comb begin
        en_set = wr_en && (wr_addr == A_ENABLE) &&  wr_data[0];
        en_clr = wr_en && (wr_addr == A_ENABLE) && !wr_data[0];
        clr    = wr_en && (wr_addr == A_CLEAR)  &&  wr_data[0];
    end

    // staging copy: host writes land here
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_LINE:   begin
                    stg_q.lper <= wr_data[16 +: HW];
                    stg_q.hsw  <= wr_data[0 +: HW];
                end
                A_FPER:   stg_q.fper   <= wr_data[FW-1:0];
                A_VSW:    stg_q.vsw    <= wr_data[FW-1:0];
                A_HWIN:   begin
                    stg_q.hend   <= wr_data[16 +: HW];
                    stg_q.hstart <= wr_data[0 +: HW];
                end
                A_VSTART: stg_q.vstart <= wr_data[FW-1:0];
                A_VEND:   stg_q.vend   <= wr_data[FW-1:0];
                A_POL:    stg_q.pol    <= wr_data[PW-1:0];
                default:  ;
            endcase
        end
    end

    // working copy: follows staging while stopped, reloads at frame wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!run || frame_wrap) begin
            act_q <= stg_q;
        end
    end

    assign act = act_q;
endmodule

// File: rtl/tg_sequencer.sv
module tg_sequencer
    import tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_set,
    input  logic          en_clr,
    input  tg_cfg_t       act,
    output logic          run,
    output logic          frame_wrap,
    output logic [FW-1:0] fcnt,
    output logic [HW-1:0] hcnt
);
    tg_state_e state_q, state_d;
    logic [FW-1:0] fcnt_q;
    logic [HW-1:0] hcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TG_IDLE: if (en_set) state_d = TG_RUN;
            TG_RUN:  if (en_clr) state_d = TG_IDLE;
            default: state_d = TG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run        = (state_q == TG_RUN);
        frame_wrap = run && (fcnt_q >= act.fper - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q <= '0;
            hcnt_q <= '0;
        end else if (!run || en_clr || frame_wrap) begin
            fcnt_q <= '0;
            hcnt_q <= '0;
        end else begin
            fcnt_q <= fcnt_q + 1'b1;
            hcnt_q <= (hcnt_q >= act.lper - 1'b1) ? '0 : hcnt_q + 1'b1;
        end
    end

    assign fcnt = fcnt_q;
    assign hcnt = hcnt_q;
endmodule

// File: rtl/tg_decode.sv
module tg_decode
    import tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          frame_wrap,
    input  logic          clr,
    input  tg_cfg_t       act,
    input  logic [FW-1:0] fcnt,
    input  logic [HW-1:0] hcnt,
    output logic          fs_set,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          frame_start_o,
    output logic          frame_irq_o,
    output logic [HW-1:0] pix_x_o,
    output logic [HW-1:0] pix_y_o
);
    logic          hs_lvl, vs_lvl, de_lvl;
    logic          first_q;
    logic [HW-1:0] y_d;

    always_comb begin
        fs_set = run && (fcnt == '0);
        hs_lvl = run && (hcnt < act.hsw);
        vs_lvl = run && (fcnt < act.vsw);
        de_lvl = run && (fcnt >= act.vstart) && (fcnt <= act.vend)
                     && (hcnt >= act.hstart) && (hcnt <= act.hend);
        if (!de_lvl)                 y_d = pix_y_o;
        else if (first_q)            y_d = '0;
        else if (hcnt == act.hstart) y_d = pix_y_o + 1'b1;
        else                         y_d = pix_y_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_o       <= 1'b0;
            vsync_o       <= 1'b0;
            de_o          <= 1'b0;
            frame_start_o <= 1'b0;
            frame_irq_o   <= 1'b0;
            pix_x_o       <= '0;
            pix_y_o       <= '0;
            first_q       <= 1'b1;
        end else begin
            hsync_o       <= hs_lvl ^ act.pol[0];
            vsync_o       <= vs_lvl ^ act.pol[1];
            de_o          <= de_lvl ^ act.pol[2];
            frame_start_o <= fs_set;
            frame_irq_o   <= fs_set | (frame_irq_o & ~clr);
            pix_x_o       <= de_lvl ? (hcnt - act.hstart) : '0;
            pix_y_o       <= y_d;
            if (!run || frame_wrap) first_q <= 1'b1;
            else if (de_lvl)        first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          frame_start_o,
    output logic          frame_irq_o,
    output logic [HW-1:0] pix_x_o,
    output logic [HW-1:0] pix_y_o
);
    tg_cfg_t       act_w;
    logic          run_w, wrap_w, en_set_w, en_clr_w, clr_w, fs_set_w;
    logic [FW-1:0] fcnt_w;
    logic [HW-1:0] hcnt_w;

    tg_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run_w), .frame_wrap(wrap_w), .act(act_w),
        .en_set(en_set_w), .en_clr(en_clr_w), .clr(clr_w)
    );

    tg_sequencer seq_i (
        .clk(clk), .rst_n(rst_n), .en_set(en_set_w), .en_clr(en_clr_w),
        .act(act_w), .run(run_w), .frame_wrap(wrap_w),
        .fcnt(fcnt_w), .hcnt(hcnt_w)
    );

    tg_decode dec_i (
        .clk(clk), .rst_n(rst_n), .run(run_w), .frame_wrap(wrap_w),
        .clr(clr_w), .act(act_w), .fcnt(fcnt_w), .hcnt(hcnt_w),
        .fs_set(fs_set_w), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .frame_start_o(frame_start_o),
        .frame_irq_o(frame_irq_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
    );
endmodule

// File: rtl/panel_timing_gen_chk.sv
module panel_timing_gen_chk
    import tg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          fs_set,
    input logic          clr,
    input tg_cfg_t       act,
    input logic [FW-1:0] fcnt,
    input logic [HW-1:0] hcnt,
    input logic          hsync_o,
    input logic          vsync_o,
    input logic          de_o,
    input logic          frame_start_o,
    input logic          frame_irq_o
);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_irq_o && !clr) |=> frame_irq_o);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fs_set) |=> !frame_irq_o);

    a_r8_start_flags_irq: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> frame_irq_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!frame_start_o && hsync_o == $past(act.pol[0])
                  && vsync_o == $past(act.pol[1]) && de_o == $past(act.pol[2])));

    a_r3_enable_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (fcnt == '0 && hcnt == '0));

    a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act.lper != '0) |-> (hcnt < act.lper));
endmodule

bind panel_timing_gen panel_timing_gen_chk chk_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .fs_set(fs_set_w), .clr(clr_w),
    .act(act_w), .fcnt(fcnt_w), .hcnt(hcnt_w), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .frame_start_o(frame_start_o),
    .frame_irq_o(frame_irq_o)
);

// File: tb/panel_timing_gen_tb_top.sv
module panel_timing_gen_tb_top;
    import tg_pkg::*;

    typedef struct packed {
        logic          hs, vs, de, fs, irq;
        logic [HW-1:0] x, y;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          hsync_o, vsync_o, de_o, frame_start_o, frame_irq_o;
    logic [HW-1:0] pix_x_o, pix_y_o;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;
    string phase = "R1";
    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    panel_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .frame_start_o(frame_start_o),
        .frame_irq_o(frame_irq_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
    );

    // reference model built from the requirements; pushes one expected item per edge
    tg_cfg_t       stg, act;
    logic          m_run, m_first, m_irq, m_wrap;
    logic [FW-1:0] m_f;
    logic [HW-1:0] m_h, m_y;
    logic          c_clr, c_set, c_off, c_fs, c_de;
    exp_t          e;

    always @(posedge clk) begin
        if (!rst_n) begin
            stg = '0; act = '0; m_run = 0; m_first = 1; m_irq = 0;
            m_f = '0; m_h = '0; m_y = '0;
        end else begin
            c_clr = wr_en && wr_addr == 4'd8 && wr_data[0];
            c_set = wr_en && wr_addr == 4'd0 && wr_data[0];
            c_off = wr_en && wr_addr == 4'd0 && !wr_data[0];
            c_fs  = m_run && m_f == 0;
            c_de  = m_run && m_f >= act.vstart && m_f <= act.vend
                          && m_h >= act.hstart && m_h <= act.hend;
            e.hs  = (m_run && m_h < act.hsw) ^ act.pol[0];
            e.vs  = (m_run && m_f < act.vsw) ^ act.pol[1];
            e.de  = c_de ^ act.pol[2];
            e.fs  = c_fs;
            e.irq = c_fs | (m_irq & !c_clr);
            if (c_de) begin
                e.x = m_h - act.hstart;
                e.y = m_first ? 12'd0 : ((m_h == act.hstart) ? m_y + 12'd1 : m_y);
            end else begin
                e.x = '0;
                e.y = m_y;
            end
            q.push_back(e);
            m_irq = e.irq;
            m_y   = e.y;
            if (c_de) m_first = 0;
            m_wrap = m_run && (m_f >= act.fper - 1);
            if (!m_run) begin
                act = stg; m_first = 1;
                if (c_set) m_run = 1;
            end else if (c_off) begin
                m_run = 0; m_f = '0; m_h = '0;
            end else if (m_wrap) begin
                act = stg; m_first = 1; m_f = '0; m_h = '0;
            end else begin
                m_f = m_f + 1;
                m_h = (m_h >= act.lper - 1) ? 12'd0 : m_h + 12'd1;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd1: begin stg.lper = wr_data[27:16]; stg.hsw = wr_data[11:0]; end
                    4'd2: stg.fper = wr_data[23:0];
                    4'd3: stg.vsw = wr_data[23:0];
                    4'd4: begin stg.hend = wr_data[27:16]; stg.hstart = wr_data[11:0]; end
                    4'd5: stg.vstart = wr_data[23:0];
                    4'd6: stg.vend = wr_data[23:0];
                    4'd7: stg.pol = wr_data[2:0];
                    default: ;
                endcase
            end
        end
    end

    // monitor: pops expected items away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            logic bad;
            x = q.pop_front();
            bad = 0;
            n_vec++;
            if (hsync_o !== x.hs) begin bad = 1;
                $display("FAIL R4 [%s] hsync act=%b exp=%b", phase, hsync_o, x.hs); end
            if (vsync_o !== x.vs) begin bad = 1;
                $display("FAIL R5 [%s] vsync act=%b exp=%b", phase, vsync_o, x.vs); end
            if (de_o !== x.de) begin bad = 1;
                $display("FAIL R6 [%s] de act=%b exp=%b", phase, de_o, x.de); end
            if (frame_start_o !== x.fs) begin bad = 1;
                $display("FAIL R8 [%s] frame_start act=%b exp=%b", phase, frame_start_o, x.fs); end
            if (frame_irq_o !== x.irq) begin bad = 1;
                $display("FAIL R9 [%s] irq act=%b exp=%b", phase, frame_irq_o, x.irq); end
            if (pix_x_o !== x.x || pix_y_o !== x.y) begin bad = 1;
                $display("FAIL R12 [%s] xy act=%0d,%0d exp=%0d,%0d", phase,
                         pix_x_o, pix_y_o, x.x, x.y); end
            if (bad) n_bad++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // line 10, hsync 2, window 3..8, frame 60 (6 lines), vsync 1 line, active lines 2..4
    task automatic cfg_base(input logic [23:0] vs0, input logic [23:0] ve0);
        wr(4'd1, {4'd0, 12'd10, 4'd0, 12'd2});
        wr(4'd2, 32'd60);
        wr(4'd3, 32'd10);
        wr(4'd4, {4'd0, 12'd8, 4'd0, 12'd3});
        wr(4'd5, {8'd0, vs0});
        wr(4'd6, {8'd0, ve0});
        wr(4'd7, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        phase = "R1";
        n_vec++;
        if (hsync_o !== 0 || vsync_o !== 0 || de_o !== 0 || frame_start_o !== 0
            || frame_irq_o !== 0 || pix_x_o !== 0 || pix_y_o !== 0) begin
            n_bad++;
            $display("FAIL R1 reset outputs act=%b%b%b%b%b/%0d/%0d exp=00000/0/0",
                     hsync_o, vsync_o, de_o, frame_start_o, frame_irq_o, pix_x_o, pix_y_o);
        end
        rst_n = 1'b1;
        idle(4);
        phase = "R2 program";
        cfg_base(24'd20, 24'd49);
        phase = "R3 run";
        wr(4'd0, 32'd1);
        idle(130);
        phase = "R11 staged";
        wr(4'd1, {4'd0, 12'd10, 4'd0, 12'd4});
        wr(4'd7, 32'd7);          // R7 polarity inversion, staged too
        idle(130);
        phase = "R9 clear";
        for (int i = 0; i < 20; i++) begin
            wr(4'd8, (i % 3 == 0) ? 32'd0 : 32'd1);
            idle(3 + (i % 4));
        end
        phase = "R2 bad address";
        wr(4'd12, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
        idle(70);
        phase = "R10 stop";
        wr(4'd0, 32'd0);
        idle(12);
        phase = "R11 idle writes";
        wr(4'd7, 32'd0);
        cfg_base(24'd25, 24'd54);  // skewed window starts mid-line
        idle(5);
        phase = "R12 skew run";
        wr(4'd0, 32'd1);
        wr(4'd0, 32'd1);          // enable again while running: no effect
        idle(140);
        phase = "R10 stop again";
        wr(4'd0, 32'd0);
        idle(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired in phase %s act=running exp=done", phase);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule